// File: doc/BRIEF.md
# Time-Shared Address Port Latch

This block assembles a wide programming address from a narrow input port that carries two different things at different times. A select strobe decides what the port means. While the strobe is high, the port carries the upper address bits. When the strobe falls, those upper bits are captured and kept. From then on, the port carries the low byte, and the block combines both parts into one address word.

The upper bits are taken only from a strobe pulse that was long enough. A pulse that is too short leaves the held upper bits as they were and raises a sticky error flag. The assembled address is reported as valid only after the low byte has been held unchanged, with the strobe low, for a fixed settling count. If the low byte changes, the block withdraws the valid flag and starts the count again. The strobe needs to be pulsed again only when the upper bits must change.

Top module: `addr_mux_latch`

## Requirements
- R1: While `rst` is sampled high, the next outputs are `addr_out` = 0, `addr_valid` = 0 and `hold_err` = 0. After reset the upper address bits read 0 until a strobe pulse is accepted.
- R2: In the cycle after any clock edge that samples `sel` high, `addr_valid` is 0.
- R3: `addr_out[10:8]` is loaded from `port_in[2:0]` as it was sampled at the last edge with `sel` high. The load happens at the first edge that samples `sel` low, and only if `sel` was sampled high on at least 13 consecutive edges just before it.
- R4: If `sel` falls after fewer than 13 consecutive high samples, `addr_out[10:8]` keeps its previous value and `hold_err` goes to 1 after that first low edge.
- R5: Once set, `hold_err` stays 1 until reset, including across later accepted strobe pulses.
- R6: `addr_valid` becomes 1 after the 13th consecutive edge that samples `sel` low with `port_in` equal to its value at the previous edge. The count starts with the first low edge after a fall, or with the edge at which the byte changed, which is counted as 1.
- R7: A change of `port_in` sampled while `sel` is low makes `addr_valid` 0 in the next cycle and restarts the 13-edge count from that edge.
- R8: `addr_out[10:8]` keeps its value through any number of low-byte changes, and changes only through an accepted strobe pulse (R3) or reset.
- R9: `addr_out[7:0]` equals `port_in` as sampled at the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Select strobe: high means the port carries the upper bits |
| port_in | input | 8 | Time-shared address port |
| addr_out | output | 11 | Assembled address: upper bits held, low byte as sampled |
| addr_valid | output | 1 | High when the low byte has settled with the strobe low |
| hold_err | output | 1 | Sticky flag for a strobe pulse shorter than the minimum |

## Verification
Two functions can act on the same clock edge: judging the strobe pulse on its falling edge, which either loads the upper bits or sets the error, and restarting the settling count for the low byte. The bench provokes this with a 12-cycle pulse directly followed by a new low byte. It checks that in the first low cycle the error is already set, the upper bits are unchanged and the count has begun, so that the valid flag appears after exactly 13 low edges. A second collision is a low-byte change on the very edge where the valid flag would otherwise have risen. Here the flag must stay low and rise only after 13 further edges.

// File: rtl/addr_mux_pkg.sv
package addr_mux_pkg;

    // Strobe phase as seen at one clock edge (current vs previous sample)
    typedef enum logic [1:0] {
        PH_LOW  = 2'b00,
        PH_RISE = 2'b01,
        PH_HIGH = 2'b11,
        PH_FALL = 2'b10
    } strobe_phase_e;

    // Decision taken on the upper-bit latch at one edge
    typedef struct packed {
        logic load;
        logic reject;
    } hi_action_t;

    function automatic strobe_phase_e classify(input logic now_s, input logic prev_s);
        strobe_phase_e ph;
        case ({prev_s, now_s})
            2'b00:   ph = PH_LOW;
            2'b01:   ph = PH_RISE;
            2'b11:   ph = PH_HIGH;
            default: ph = PH_FALL;
        endcase
        return ph;
    endfunction

endpackage

// File: rtl/hi_capture.sv
module hi_capture
    import addr_mux_pkg::*;
#(
    parameter int HI_W     = 3,
    parameter int MIN_HIGH = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel,
    input  logic [HI_W-1:0] hi_in,
    output logic [HI_W-1:0] hi_bits,
    output logic            hold_err
);
    localparam int CW = $clog2(MIN_HIGH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_HIGH);

    logic            sel_q;
    logic [CW-1:0]   high_cnt;
    logic [HI_W-1:0] shadow;
    strobe_phase_e   phase;
    hi_action_t      act;

    always_comb begin
        phase      = classify(sel, sel_q);
        act.load   = (phase == PH_FALL) && (high_cnt == CNT_MAX);
        act.reject = (phase == PH_FALL) && (high_cnt != CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b0;
            high_cnt <= '0;
            shadow   <= '0;
            hi_bits  <= '0;
            hold_err <= 1'b0;
        end else begin
            sel_q <= sel;
            if (sel) begin
                shadow <= hi_in;
                if (high_cnt != CNT_MAX)
                    high_cnt <= high_cnt + 1'b1;
            end else begin
                high_cnt <= '0;
            end
            if (act.load)
                hi_bits <= shadow;
            if (act.reject)
                hold_err <= 1'b1;
        end
    end

endmodule

// File: rtl/settle_tracker.sv
module settle_tracker #(
    parameter int PORT_W = 8,
    parameter int SETTLE = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic [PORT_W-1:0] port_in,
    output logic [PORT_W-1:0] lo_byte,
    output logic              settled
);
    localparam int CW = $clog2(SETTLE + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(SETTLE);

    logic          sel_q;
    logic [CW-1:0] run_cnt;
    logic          restart;

    assign restart = sel_q || (port_in != lo_byte);
    assign settled = (run_cnt == RUN_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            lo_byte <= '0;
            run_cnt <= '0;
        end else begin
            sel_q   <= sel;
            lo_byte <= port_in;
            if (sel)
                run_cnt <= '0;
            else if (restart)
                run_cnt <= CW'(1);
            else if (run_cnt != RUN_MAX)
                run_cnt <= run_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/addr_mux_latch.sv
module addr_mux_latch #(
    parameter int PORT_W   = 8,
    parameter int ADDR_W   = 11,
    parameter int MIN_HIGH = 13,
    parameter int SETTLE   = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic [PORT_W-1:0] port_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_valid,
    output logic              hold_err
);
    localparam int HI_W = ADDR_W - PORT_W;

    logic [HI_W-1:0]   hi_bits;
    logic [PORT_W-1:0] lo_byte;

    hi_capture #(.HI_W(HI_W), .MIN_HIGH(MIN_HIGH)) u_hi (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .hi_in    (port_in[HI_W-1:0]),
        .hi_bits  (hi_bits),
        .hold_err (hold_err)
    );

    settle_tracker #(.PORT_W(PORT_W), .SETTLE(SETTLE)) u_lo (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .port_in (port_in),
        .lo_byte (lo_byte),
        .settled (addr_valid)
    );

    assign addr_out = {hi_bits, lo_byte};

endmodule

// File: rtl/addr_mux_latch_chk.sv
module addr_mux_latch_chk #(
    parameter int PORT_W = 8,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              sel,
    input logic [PORT_W-1:0] port_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              addr_valid,
    input logic              hold_err
);
    // R2
    strobe_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
        sel |=> !addr_valid);

    // R7
    byte_change_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel && (port_in != $past(port_in))) |=> !addr_valid);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        hold_err |=> hold_err);

    // R8
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sel || !$past(sel)) |=> $stable(addr_out[ADDR_W-1:PORT_W]));

    // R6
    valid_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_valid) |-> !$past(sel));

    // R4
    err_only_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_err) |-> (!$past(sel) && $past(sel, 2)));

endmodule

bind addr_mux_latch addr_mux_latch_chk #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .port_in    (port_in),
    .addr_out   (addr_out),
    .addr_valid (addr_valid),
    .hold_err   (hold_err)
);

// File: tb/addr_mux_latch_test.sv
module addr_mux_latch_test;
    localparam int PW = 8;
    localparam int AW = 11;
    localparam int HW = AW - PW;
    localparam int MINH = 13;
    localparam int SETL = 13;

    typedef struct {
        bit          chk;
        logic [AW-1:0] addr;
        bit          valid;
        bit          err;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic [PW-1:0] port_in = '0;
    logic [AW-1:0] addr_out;
    logic          addr_valid;
    logic          hold_err;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   timed_out = 0;

    logic [HW-1:0] cur_hi = '0;
    bit            cur_err = 0;
    bit            pend = 0;
    bit            pend_ok = 0;
    logic [HW-1:0] pend_hi = '0;

    addr_mux_latch #(.PORT_W(PW), .ADDR_W(AW), .MIN_HIGH(MINH), .SETTLE(SETL)) uut (
        .clk(clk), .rst(rst), .sel(sel), .port_in(port_in),
        .addr_out(addr_out), .addr_valid(addr_valid), .hold_err(hold_err)
    );

    always #5 clk = ~clk;

    // monitor: pops one expectation per edge and compares
    always begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            if (it.chk) begin
                n_checks++;
                if (addr_out !== it.addr || addr_valid !== it.valid || hold_err !== it.err) begin
                    n_fail++;
                    $display("FAIL %s: addr=%h valid=%b err=%b expected addr=%h valid=%b err=%b",
                             it.tag, addr_out, addr_valid, hold_err, it.addr, it.valid, it.err);
                end
            end
        end
    end

    task automatic step(bit s, logic [PW-1:0] p, logic [AW-1:0] a, bit v, bit e, string tag);
        exp_t it;
        @(negedge clk);
        sel = s;
        port_in = p;
        it.chk = 1; it.addr = a; it.valid = v; it.err = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic do_reset(int n);
        exp_t it;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst = 1'b1; sel = 1'b0; port_in = '0;
            it.chk = 1; it.addr = '0; it.valid = 0; it.err = 0; it.tag = "R1";
            q.push_back(it);
        end
        @(negedge clk);
        rst = 1'b0;
        it.chk = 0; it.addr = '0; it.valid = 0; it.err = 0; it.tag = "";
        q.push_back(it);
        cur_hi = '0; cur_err = 0; pend = 0;
    endtask

    // R2: strobe held high for n edges
    task automatic strobe(logic [PW-1:0] b, int n);
        for (int i = 0; i < n; i++)
            step(1'b1, b, {cur_hi, b}, 1'b0, cur_err, "R2");
        pend = 1; pend_ok = (n >= MINH); pend_hi = b[HW-1:0];
    endtask

    // low phase, byte differs from the previous sample or follows a strobe
    task automatic low_run(logic [PW-1:0] b, int n, string tag);
        for (int i = 1; i <= n; i++) begin
            if (i == 1 && pend) begin
                if (pend_ok) cur_hi = pend_hi;
                else cur_err = 1;
                pend = 0;
            end
            step(1'b0, b, {cur_hi, b}, (i >= SETL), cur_err, tag);
        end
    endtask

    initial begin
        fork
            begin
                do_reset(3);
                // R3: accepted pulse, high bits held two extra clocks
                strobe(8'h05, 13);
                low_run(8'h05, 2, "R3");
                // R6 / R9: settle count from a byte change
                low_run(8'hA7, 14, "R6");
                // R8 then R7: change on the edge valid would rise
                low_run(8'h3C, 12, "R8");
                low_run(8'h3D, 13, "R7");
                // R4: 12-cycle pulse, collides with restart of settling
                strobe(8'h02, 12);
                low_run(8'h11, 13, "R4");
                // R5: accepted pulse keeps error set
                strobe(8'h06, 13);
                low_run(8'h22, 13, "R5");
                // R9: long pulse, same byte kept after fall
                strobe(8'hFF, 20);
                low_run(8'hFF, 13, "R9");
                // R1: reset in the middle of a run
                low_run(8'h44, 6, "R1");
                do_reset(2);
                low_run(8'h44, 13, "R1");
                wait (q.size() == 0);
                @(posedge clk);
                #3;
            end
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule